// File: doc/BRIEF.md
# UART Register and Interrupt Controller

This block is the software-facing register layer of a simple serial port. A processor reaches it over a plain 32-bit register bus. The bus has a byte address, separate read and write strobes, write data, registered read data, a one-cycle acknowledge and an error flag. Behind the block sit a receive character FIFO and a transmit character FIFO, each 16 deep, and a serial engine that reports overrun, framing and parity events as single-cycle pulses. The block turns bus accesses into pop, push and clear strobes for those FIFOs. It folds FIFO state and error history into a status word and drives a single interrupt line.

Four word-aligned registers are decoded. Offset 0x0 returns the oldest received character. Offset 0x4 accepts a character to send. Offset 0x8 reports status. Offset 0xC takes commands. The three error flags are sticky. They stay set until software reads the status register, and that read clears them. The interrupt is edge-like rather than level-like. It pulses for one cycle when the receive FIFO stops being empty or when the transmit FIFO drains, and only while the interrupt is enabled.

Bus handling is a two-state machine. ST_IDLE accepts a request. ST_ACK presents the registered response for exactly one cycle. The transition ST_IDLE to ST_ACK happens on any read or write strobe. The transition ST_ACK to ST_IDLE is taken unconditionally. Strobes that arrive during ST_ACK are ignored.

Top module: `uart_regblock`

## Requirements
- R1: A read or write strobe seen in ST_IDLE is answered by `bus_ack` high for exactly one cycle, in the cycle that follows the strobe. If both strobes are high together, the read is taken.
- R2: A read of offset 0x0 while `rxf_empty` is low pulses `rxf_pop` in the request cycle. It returns `rxf_data` in the low DATA_W bits, with zeros above, and `bus_err` stays low.
- R3: A read of offset 0x0 while `rxf_empty` is high returns `bus_err` high together with the acknowledge and read data of zero, and does not pulse `rxf_pop`.
- R4: A write to offset 0x4 pulses `txf_push` in the request cycle and presents the write data on `txf_wdata`.
- R5: Writes to offsets 0x0 and 0x8 are acknowledged and change nothing: no pop, push or clear, and the error flags are kept. Reads of offsets 0x4 and 0xC are acknowledged with data zero.
- R6: Status at offset 0x8 uses these bit positions, counted from the LSB: bit 0 receive FIFO not empty, bit 1 receive FIFO full, bit 2 transmit FIFO empty, bit 3 transmit FIFO full, bit 4 interrupt enabled, bit 5 overrun, bit 6 framing error, bit 7 parity error. All higher bits are zero. After reset, with the transmit FIFO empty and the receive FIFO empty, status reads 0x04.
- R7: An overrun, framing or parity pulse sets its flag, and the flag stays set until a status read clears it. The read itself returns the value the flags held before it. A pulse in the same cycle as a status read leaves its flag set after the read.
- R8: A write to offset 0xC with bit 0 set pulses `txf_clear`, and with bit 1 set pulses `rxf_clear`, both in the request cycle. A 0 in either bit produces no pulse.
- R9: Bit 4 of every write to offset 0xC becomes the interrupt enable, which status bit 4 reflects. The enable is 0 after reset.
- R10: While enabled, `irq` is high for exactly the first cycle in which `rxf_empty` is low after having been high.
- R11: While enabled, `irq` is high for exactly the first cycle in which `txf_empty` is high after having been low.
- R12: `irq` stays low while the enable is 0. It also stays low on the opposite transitions: the receive FIFO becoming empty, or the transmit FIFO becoming non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, valid with acknowledge, zero otherwise |
| bus_ack | output | 1 | Access acknowledge |
| bus_err | output | 1 | Access error, valid with acknowledge |
| rxf_empty | input | 1 | Receive FIFO empty |
| rxf_full | input | 1 | Receive FIFO full |
| rxf_data | input | DATA_W | Oldest receive FIFO entry |
| rxf_pop | output | 1 | Remove the oldest receive entry |
| rxf_clear | output | 1 | Flush the receive FIFO |
| txf_empty | input | 1 | Transmit FIFO empty |
| txf_full | input | 1 | Transmit FIFO full |
| txf_push | output | 1 | Store txf_wdata in the transmit FIFO |
| txf_wdata | output | BUS_W | Write data forwarded to the transmit FIFO, which keeps the low DATA_W bits |
| txf_clear | output | 1 | Flush the transmit FIFO |
| ev_overrun | input | 1 | Overrun event pulse |
| ev_frame | input | 1 | Framing error pulse |
| ev_parity | input | 1 | Parity error pulse |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench builds the block with the defaults: BUS_W of 32 and DATA_W of 8. With these widths the zero-extension of received characters above bit 7 is checked directly, using a character with both its top and bottom bits set. The 8-bit status word then fills exactly the low byte of the read data. Because the FIFO flags are bench-driven inputs, full, empty and mixed FIFO conditions can be imposed in any combination. That makes the same-cycle error-and-read case and each interrupt transition direction reachable on demand.

// File: rtl/uart_reg_pkg.sv
`timescale 1ns/1ps
package uart_reg_pkg;

    // Register offsets (byte addresses, word aligned)
    localparam logic [3:0] OFS_RXDATA = 4'h0;
    localparam logic [3:0] OFS_TXDATA = 4'h4;
    localparam logic [3:0] OFS_STATUS = 4'h8;
    localparam logic [3:0] OFS_CTRL   = 4'hC;

    // Status bit positions
    localparam int STS_RX_VALID = 0;
    localparam int STS_RX_FULL  = 1;
    localparam int STS_TX_EMPTY = 2;
    localparam int STS_TX_FULL  = 3;
    localparam int STS_IEN      = 4;
    localparam int STS_ERR_LSB  = 5;
    localparam int STS_W        = 8;

    // Error flag indices inside the sticky flag vector
    localparam int ERR_OVERRUN = 0;
    localparam int ERR_FRAME   = 1;
    localparam int ERR_PARITY  = 2;
    localparam int NUM_ERR     = 3;

    // Control bit positions
    localparam int CTL_TX_CLR = 0;
    localparam int CTL_RX_CLR = 1;
    localparam int CTL_IEN    = 4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } bus_state_e;

endpackage

// File: rtl/uart_err_flags.sv
`timescale 1ns/1ps
module uart_err_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic         clr,
    output logic [N-1:0] flags
);

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_flag
            logic flag_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flag_q <= 1'b0;
                end else if (ev[gi]) begin
                    // a new event wins over a clearing read
                    flag_q <= 1'b1;
                end else if (clr) begin
                    flag_q <= 1'b0;
                end
            end
            assign flags[gi] = flag_q;
        end
    endgenerate

endmodule

// File: rtl/uart_irq_gen.sv
`timescale 1ns/1ps
module uart_irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic ien,
    input  logic rx_empty,
    input  logic tx_empty,
    output logic irq
);

    logic rx_empty_prev;
    logic tx_empty_prev;
    logic rx_arrive;
    logic tx_drain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_empty_prev <= 1'b1;
            tx_empty_prev <= 1'b1;
        end else begin
            rx_empty_prev <= rx_empty;
            tx_empty_prev <= tx_empty;
        end
    end

    always_comb begin
        rx_arrive = rx_empty_prev && !rx_empty;
        tx_drain  = !tx_empty_prev && tx_empty;
        irq       = ien && (rx_arrive || tx_drain);
    end

endmodule

// File: rtl/uart_bus_fsm.sv
`timescale 1ns/1ps
module uart_bus_fsm
    import uart_reg_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_ack,
    output logic              bus_err,
    input  logic              rxf_empty,
    input  logic [DATA_W-1:0] rxf_data,
    input  logic [STS_W-1:0]  status,
    output logic              rxf_pop,
    output logic              txf_push,
    output logic              txf_clear,
    output logic              rxf_clear,
    output logic              ien_we,
    output logic              ien_val,
    output logic              status_rd
);

    localparam int RX_PAD  = BUS_W - DATA_W;
    localparam int STS_PAD = BUS_W - STS_W;

    bus_state_e state_q;
    bus_state_e state_d;

    logic             rd_req;
    logic             wr_req;
    logic             sel_rx;
    logic             sel_tx;
    logic             sel_sts;
    logic             sel_ctl;
    logic [BUS_W-1:0] rdata_d;
    logic [BUS_W-1:0] rdata_q;
    logic             err_d;
    logic             err_q;
    logic             ctl_we;

    // Address decode and request qualification
    always_comb begin
        sel_rx  = (bus_addr == OFS_RXDATA);
        sel_tx  = (bus_addr == OFS_TXDATA);
        sel_sts = (bus_addr == OFS_STATUS);
        sel_ctl = (bus_addr == OFS_CTRL);
        rd_req  = (state_q == ST_IDLE) && bus_rd;
        wr_req  = (state_q == ST_IDLE) && bus_wr && !bus_rd;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (bus_rd || bus_wr) state_d = ST_ACK;
            ST_ACK:  state_d = ST_IDLE;
        endcase
    end

    // State register and response capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (rd_req || wr_req) begin
                rdata_q <= rdata_d;
                err_q   <= err_d;
            end
        end
    end

    // Side-effect strobes and response data for the request cycle
    always_comb begin
        rdata_d   = '0;
        err_d     = 1'b0;
        rxf_pop   = 1'b0;
        status_rd = 1'b0;
        if (rd_req) begin
            if (sel_rx) begin
                if (rxf_empty) begin
                    err_d = 1'b1;
                end else begin
                    rxf_pop = 1'b1;
                    rdata_d = {{RX_PAD{1'b0}}, rxf_data};
                end
            end else if (sel_sts) begin
                status_rd = 1'b1;
                rdata_d   = {{STS_PAD{1'b0}}, status};
            end
        end
        txf_push  = wr_req && sel_tx;
        ctl_we    = wr_req && sel_ctl;
        txf_clear = ctl_we && bus_wdata[CTL_TX_CLR];
        rxf_clear = ctl_we && bus_wdata[CTL_RX_CLR];
        ien_we    = ctl_we;
        ien_val   = bus_wdata[CTL_IEN];
    end

    // Output decode per state
    always_comb begin
        bus_ack   = 1'b0;
        bus_err   = 1'b0;
        bus_rdata = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ACK: begin
                bus_ack   = 1'b1;
                bus_err   = err_q;
                bus_rdata = err_q ? '0 : rdata_q;
            end
        endcase
    end

endmodule

// File: rtl/uart_regblock.sv
`timescale 1ns/1ps
module uart_regblock
    import uart_reg_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_ack,
    output logic              bus_err,
    input  logic              rxf_empty,
    input  logic              rxf_full,
    input  logic [DATA_W-1:0] rxf_data,
    output logic              rxf_pop,
    output logic              rxf_clear,
    input  logic              txf_empty,
    input  logic              txf_full,
    output logic              txf_push,
    output logic [BUS_W-1:0]  txf_wdata,
    output logic              txf_clear,
    input  logic              ev_overrun,
    input  logic              ev_frame,
    input  logic              ev_parity,
    output logic              irq
);

    logic               ien_q;
    logic               ien_we;
    logic               ien_val;
    logic               status_rd;
    logic [NUM_ERR-1:0] err_ev;
    logic [NUM_ERR-1:0] err_flags;
    logic [STS_W-1:0]   status;

    always_comb begin
        err_ev[ERR_OVERRUN] = ev_overrun;
        err_ev[ERR_FRAME]   = ev_frame;
        err_ev[ERR_PARITY]  = ev_parity;
    end

    always_comb begin
        status                                  = '0;
        status[STS_RX_VALID]                    = !rxf_empty;
        status[STS_RX_FULL]                     = rxf_full;
        status[STS_TX_EMPTY]                    = txf_empty;
        status[STS_TX_FULL]                     = txf_full;
        status[STS_IEN]                         = ien_q;
        status[STS_ERR_LSB +: NUM_ERR]          = err_flags;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q <= 1'b0;
        end else if (ien_we) begin
            ien_q <= ien_val;
        end
    end

    assign txf_wdata = bus_wdata;

    uart_bus_fsm #(
        .BUS_W  (BUS_W),
        .DATA_W (DATA_W)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack),
        .bus_err   (bus_err),
        .rxf_empty (rxf_empty),
        .rxf_data  (rxf_data),
        .status    (status),
        .rxf_pop   (rxf_pop),
        .txf_push  (txf_push),
        .txf_clear (txf_clear),
        .rxf_clear (rxf_clear),
        .ien_we    (ien_we),
        .ien_val   (ien_val),
        .status_rd (status_rd)
    );

    uart_err_flags #(
        .N (NUM_ERR)
    ) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (err_ev),
        .clr   (status_rd),
        .flags (err_flags)
    );

    uart_irq_gen u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ien      (ien_q),
        .rx_empty (rxf_empty),
        .tx_empty (txf_empty),
        .irq      (irq)
    );

endmodule

// File: rtl/uart_regblock_chk.sv
`timescale 1ns/1ps
module uart_regblock_chk #(
    parameter int BUS_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic             bus_ack,
    input logic             bus_err,
    input logic [BUS_W-1:0] bus_rdata,
    input logic             rxf_empty,
    input logic             rxf_pop,
    input logic             txf_empty,
    input logic             txf_clear,
    input logic             rxf_clear,
    input logic             ien_q,
    input logic             irq
);

    assert_ack_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && !bus_ack) |=> bus_ack);

    assert_ack_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    assert_no_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rxf_pop |-> !rxf_empty);

    assert_err_zero_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_ack && bus_rdata == '0));

    assert_clear_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (txf_clear || rxf_clear) |-> bus_wr);

    assert_irq_enabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ien_q);

    // R10 and R11: a pulse only follows one of the two named transitions
    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((!rxf_empty && $past(rxf_empty)) || (txf_empty && !$past(txf_empty))));

endmodule

bind uart_regblock uart_regblock_chk #(.BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err),
    .bus_rdata (bus_rdata),
    .rxf_empty (rxf_empty),
    .rxf_pop   (rxf_pop),
    .txf_empty (txf_empty),
    .txf_clear (txf_clear),
    .rxf_clear (rxf_clear),
    .ien_q     (ien_q),
    .irq       (irq)
);

// File: tb/uart_regblock_tb.sv
`timescale 1ns/1ps
module uart_regblock_tb;

    localparam int BUS_W  = 32;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_rd = 1'b0;
    logic              bus_wr = 1'b0;
    logic [3:0]        bus_addr = '0;
    logic [BUS_W-1:0]  bus_wdata = '0;
    logic [BUS_W-1:0]  bus_rdata;
    logic              bus_ack;
    logic              bus_err;
    logic              rxf_empty = 1'b1;
    logic              rxf_full = 1'b0;
    logic [DATA_W-1:0] rxf_data = '0;
    logic              rxf_pop;
    logic              rxf_clear;
    logic              txf_empty = 1'b1;
    logic              txf_full = 1'b0;
    logic              txf_push;
    logic [BUS_W-1:0]  txf_wdata;
    logic              txf_clear;
    logic              ev_overrun = 1'b0;
    logic              ev_frame = 1'b0;
    logic              ev_parity = 1'b0;
    logic              irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    uart_regblock #(.BUS_W(BUS_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .rxf_empty(rxf_empty),
        .rxf_full(rxf_full), .rxf_data(rxf_data), .rxf_pop(rxf_pop),
        .rxf_clear(rxf_clear), .txf_empty(txf_empty), .txf_full(txf_full),
        .txf_push(txf_push), .txf_wdata(txf_wdata), .txf_clear(txf_clear),
        .ev_overrun(ev_overrun), .ev_frame(ev_frame), .ev_parity(ev_parity),
        .irq(irq)
    );

    typedef struct packed {
        logic        is_wr;
        logic [3:0]  addr;
        logic [31:0] wdata;
        logic        rx_empty;
        logic        rx_full;
        logic        tx_empty;
        logic        tx_full;
        logic [7:0]  rx_data;
        logic [31:0] exp_rdata;
        logic        exp_err;
        logic        exp_pop;
        logic        exp_push;
        logic        exp_txclr;
        logic        exp_rxclr;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        // R2: read with data, top and bottom bits set
        '{1'b0, 4'h0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h81, 32'h81, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        // R3: read of empty receive FIFO
        '{1'b0, 4'h0, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h5A, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        // R4: transmit write
        '{1'b1, 4'h4, 32'h3C, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        // R5: read of transmit register is zero
        '{1'b0, 4'h4, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h77, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        // R5: read of control register is zero
        '{1'b0, 4'hC, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h77, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        // R5: write to receive register does nothing
        '{1'b1, 4'h0, 32'hFF, 1'b0, 1'b0, 1'b1, 1'b0, 8'h77, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        // R6: status with both FIFOs full
        '{1'b0, 4'h8, 32'h0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 32'h0B, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        // R8: clear both FIFOs (bit 4 = 0 keeps interrupt disabled)
        '{1'b1, 4'hC, 32'h3, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        // R8: zero bits clear nothing
        '{1'b1, 4'hC, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        // R5: write to status does nothing
        '{1'b1, 4'h8, 32'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    logic s_pop, s_push, s_txclr, s_rxclr;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One access: strobe driven at a falling edge, response sampled one cycle later
    task automatic access(input logic wr, input logic [3:0] addr, input logic [31:0] wd,
                          input logic [2:0] ev);
        @(negedge clk);
        bus_rd = !wr; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        {ev_parity, ev_frame, ev_overrun} = ev;
        #1;
        s_pop = rxf_pop; s_push = txf_push; s_txclr = txf_clear; s_rxclr = rxf_clear;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        {ev_parity, ev_frame, ev_parity} = 3'b000;
        ev_overrun = 1'b0;
        chk("R1 ack", {31'b0, bus_ack}, 32'h1);
    endtask

    task automatic pulse_ev(input logic [2:0] ev);
        @(negedge clk);
        {ev_parity, ev_frame, ev_overrun} = ev;
        @(negedge clk);
        {ev_parity, ev_frame, ev_overrun} = 3'b000;
    endtask

    task automatic read_status(input string req, input logic [31:0] exp);
        access(1'b0, 4'h8, 32'h0, 3'b000);
        chk(req, bus_rdata, exp);
    endtask

    initial begin : watchdog
        #(8 * 20000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1, R6: idle outputs and reset status
        chk("R1 reset ack", {31'b0, bus_ack}, 32'h0);
        chk("R12 reset irq", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        read_status("R6 reset status", 32'h04);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            rxf_empty = VECS[i].rx_empty; rxf_full = VECS[i].rx_full;
            txf_empty = VECS[i].tx_empty; txf_full = VECS[i].tx_full;
            rxf_data  = VECS[i].rx_data;
            access(VECS[i].is_wr, VECS[i].addr, VECS[i].wdata, 3'b000);
            chk($sformatf("R2 R3 R5 R6 vec%0d rdata", i), bus_rdata, VECS[i].exp_rdata);
            chk($sformatf("R3 vec%0d err", i), {31'b0, bus_err}, {31'b0, VECS[i].exp_err});
            chk($sformatf("R2 vec%0d pop", i), {31'b0, s_pop}, {31'b0, VECS[i].exp_pop});
            chk($sformatf("R4 vec%0d push", i), {31'b0, s_push}, {31'b0, VECS[i].exp_push});
            chk($sformatf("R8 vec%0d txclr", i), {31'b0, s_txclr}, {31'b0, VECS[i].exp_txclr});
            chk($sformatf("R8 vec%0d rxclr", i), {31'b0, s_rxclr}, {31'b0, VECS[i].exp_rxclr});
            if (VECS[i].exp_push)
                chk("R4 txf_wdata", txf_wdata, VECS[i].wdata);
        end

        @(negedge clk);
        rxf_empty = 1'b1; rxf_full = 1'b0; txf_empty = 1'b1; txf_full = 1'b0;

        // R1: both strobes together take the read
        @(negedge clk);
        bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h11;
        #1;
        chk("R1 read priority push", {31'b0, txf_push}, 32'h0);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;

        // R7: sticky overrun, cleared by read
        pulse_ev(3'b001);
        read_status("R7 overrun set", 32'h24);
        read_status("R7 overrun cleared", 32'h04);

        // R5, R7: a write to status keeps the flag
        pulse_ev(3'b010);
        access(1'b1, 4'h8, 32'hFF, 3'b000);
        read_status("R5 R7 frame kept after write", 32'h44);
        read_status("R7 frame cleared", 32'h04);

        // R7: event in the same cycle as the read survives
        access(1'b0, 4'h8, 32'h0, 3'b100);
        chk("R7 same-cycle read value", bus_rdata, 32'h04);
        read_status("R7 parity survives", 32'h84);
        read_status("R7 parity cleared", 32'h04);

        // R9: enable visible in status
        access(1'b1, 4'hC, 32'h10, 3'b000);
        read_status("R9 enable set", 32'h14);

        // R10: receive arrival pulse
        @(negedge clk); rxf_empty = 1'b0; #1;
        chk("R10 irq on rx arrival", {31'b0, irq}, 32'h1);
        @(negedge clk); #1;
        chk("R10 irq one cycle", {31'b0, irq}, 32'h0);
        // R12: rx becoming empty gives nothing
        @(negedge clk); rxf_empty = 1'b1; #1;
        chk("R12 no irq on rx empty", {31'b0, irq}, 32'h0);
        // R12: tx becoming non-empty gives nothing
        @(negedge clk); txf_empty = 1'b0; #1;
        chk("R12 no irq on tx fill", {31'b0, irq}, 32'h0);
        // R11: transmit drain pulse
        @(negedge clk); txf_empty = 1'b1; #1;
        chk("R11 irq on tx drain", {31'b0, irq}, 32'h1);
        @(negedge clk); #1;
        chk("R11 irq one cycle", {31'b0, irq}, 32'h0);

        // R9, R12: disable, then transitions give no pulse
        access(1'b1, 4'hC, 32'h0, 3'b000);
        read_status("R9 enable cleared", 32'h04);
        @(negedge clk); rxf_empty = 1'b0; #1;
        chk("R12 disabled rx arrival", {31'b0, irq}, 32'h0);
        @(negedge clk); txf_empty = 1'b0;
        @(negedge clk); txf_empty = 1'b1; #1;
        chk("R12 disabled tx drain", {31'b0, irq}, 32'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule